// File: doc/BRIEF.md
# Packet Match Status Classifier

This block follows each packet while its bytes step through a signature automaton, one byte per cycle. It keeps a small set of flags for every packet queue and turns the per-byte automaton results into a verdict. A signature that was entered from the root node is a complete match. A signature that was met without passing the root, or that was still open when the packet ended, is a partial match. A packet that ends with neither is clean and goes back to the router.

Each accepted byte carries its queue number, a start-of-packet marker, whether the current node is the root, whether a leaf was reached, whether it is the packet's last byte, and the next-node and failure values. One cycle later the block reports the verdict for that byte on its result pins. A complete match also asks the loader to flush the queue. Every later byte of that packet is then dropped with no result, until a new packet starts in the queue.

The input is a valid/ready stream. `in_ready` is high in every cycle out of reset, so the block never applies back-pressure, and a byte is taken on each rising edge where `in_valid` and `in_ready` are both high. The result pins have no ready signal. They are single-cycle pulses that the receiver must capture when `res_valid` is high.

Top module: `match_status_classifier`

## Requirements
- R1: During and right after reset all result outputs are low and every queue's flags are clear (root not visited, no flush pending, not ignoring).
- R2: `in_ready` is high in every cycle out of reset. For every accepted byte that is not dropped, `res_valid` is high in the cycle after the accepting edge, with `out_queue` equal to the byte's queue. No result pulse appears without `res_valid`, and a cycle with `in_valid` low produces no result.
- R3: A queue's root-visited flag is set by any accepted byte whose node is the root, and holds until a byte marked first arrives on that queue. A first byte clears the old flags before the byte itself is evaluated.
- R4: A byte that reaches a leaf while its queue's root-visited flag is set, counting the current byte's own root indication, gives a `cmatch` pulse.
- R5: A byte that reaches a leaf while its queue's root-visited flag is clear gives a `pmatch` pulse.
- R6: A last byte whose node is not the root and whose next-node value differs from its failure value gives a `pmatch` pulse. `cmatch` has priority, so `cmatch` and `pmatch` are never high together.
- R7: `rules_req` is high exactly when `cmatch` or `pmatch` is high.
- R8: A last byte that gives neither `cmatch` nor `pmatch` gives a `release_pkt` pulse.
- R9: `flush_req` pulses together with `cmatch`. After that, bytes of the same queue that are not marked first are dropped: they give no `res_valid` and no pulse.
- R10: Queues are independent. A byte changes only the flags of its own queue.
- R11: A first byte on a queue that is dropping bytes is processed normally and ends the dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte result present |
| in_ready | output | 1 | Block can take a byte (high out of reset) |
| in_queue | input | QW | Queue number of the byte |
| in_first | input | 1 | Byte starts a new packet |
| in_root | input | 1 | Current node is the automaton root |
| in_leaf | input | 1 | Next node is a leaf |
| in_last | input | 1 | Byte is the packet's last |
| in_next | input | PTR_W | Next-node value |
| in_fail | input | PTR_W | Failure value of the current node |
| res_valid | output | 1 | A verdict for one byte is present |
| out_queue | output | QW | Queue the verdict belongs to |
| cmatch | output | 1 | Complete match pulse |
| pmatch | output | 1 | Partial match pulse |
| flush_req | output | 1 | Ask loader to replace this queue's packet |
| release_pkt | output | 1 | Clean packet may go to the router |
| rules_req | output | 1 | Request a rules lookup |

## Verification
Every verdict is due exactly one cycle after the edge that accepts its byte. The flags involved settle at that same edge, so a byte of the same queue in the very next cycle must already see them. The driver pushes the expected verdict after that accepting edge, and the monitor compares at each falling edge, so each item is checked at the first falling edge after its edge. When the scoreboard is empty, the monitor requires that cycle to be silent. This covers dropped bytes and idle cycles.

// File: rtl/msc_pkg.sv
package msc_pkg;
  localparam int unsigned NQ_DEF    = 8;
  localparam int unsigned PTR_W_DEF = 24;

  typedef struct packed {
    logic full;
    logic part;
    logic clean;
  } verdict_t;
endpackage

// File: rtl/msc_flag_bank.sv
module msc_flag_bank #(
  parameter int unsigned NQ = 8,
  localparam int unsigned QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [QW-1:0] queue,
  input  logic          first,
  input  logic          root,
  input  logic          set_flush,
  output logic          rv_eff,
  output logic          drop_eff
);
  logic [NQ-1:0] rv_vec;
  logic [NQ-1:0] fl_vec;
  logic [NQ-1:0] ig_vec;
  logic          clr;

  assign clr      = hit & first;
  assign rv_eff   = (rv_vec[queue] & ~clr) | root;
  assign drop_eff = hit & ~clr & (ig_vec[queue] | fl_vec[queue]);

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic rv_r, fl_r, ig_r;
    logic sel;
    assign sel = hit && (queue == QW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rv_r <= 1'b0;
        fl_r <= 1'b0;
        ig_r <= 1'b0;
      end else begin
        if (fl_r) begin
          fl_r <= 1'b0;
          ig_r <= 1'b1;
        end
        if (sel) begin
          if (first) begin
            rv_r <= root;
            ig_r <= 1'b0;
            fl_r <= set_flush;
          end else if (!(ig_r | fl_r)) begin
            rv_r <= rv_r | root;
            if (set_flush) fl_r <= 1'b1;
          end
        end
      end
    end

    assign rv_vec[i] = rv_r;
    assign fl_vec[i] = fl_r;
    assign ig_vec[i] = ig_r;
  end
endmodule

// File: rtl/msc_verdict.sv
module msc_verdict
  import msc_pkg::*;
#(
  parameter int unsigned PTR_W = 24
) (
  input  logic             leaf,
  input  logic             last,
  input  logic             root,
  input  logic             rv_eff,
  input  logic [PTR_W-1:0] next_ptr,
  input  logic [PTR_W-1:0] fail_ptr,
  output verdict_t         vd
);
  logic end_open;

  assign end_open = last & ~root & (next_ptr != fail_ptr);

  always_comb begin
    vd.full  = leaf & rv_eff;
    vd.part  = ~vd.full & ((leaf & ~rv_eff) | end_open);
    vd.clean = last & ~vd.full & ~vd.part;
  end
endmodule

// File: rtl/match_status_classifier.sv
module match_status_classifier
  import msc_pkg::*;
#(
  parameter int unsigned NQ    = NQ_DEF,
  parameter int unsigned PTR_W = PTR_W_DEF,
  localparam int unsigned QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [QW-1:0]    in_queue,
  input  logic             in_first,
  input  logic             in_root,
  input  logic             in_leaf,
  input  logic             in_last,
  input  logic [PTR_W-1:0] in_next,
  input  logic [PTR_W-1:0] in_fail,
  output logic             res_valid,
  output logic [QW-1:0]    out_queue,
  output logic             cmatch,
  output logic             pmatch,
  output logic             flush_req,
  output logic             release_pkt,
  output logic             rules_req
);
  logic     acc;
  logic     rv_eff;
  logic     drop_eff;
  logic     live;
  verdict_t vd;

  assign in_ready = rst_n;
  assign acc      = in_valid & in_ready;
  assign live     = acc & ~drop_eff;

  msc_flag_bank #(.NQ(NQ)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (acc),
    .queue     (in_queue),
    .first     (in_first),
    .root      (in_root),
    .set_flush (vd.full),
    .rv_eff    (rv_eff),
    .drop_eff  (drop_eff)
  );

  msc_verdict #(.PTR_W(PTR_W)) u_vd (
    .leaf     (in_leaf),
    .last     (in_last),
    .root     (in_root),
    .rv_eff   (rv_eff),
    .next_ptr (in_next),
    .fail_ptr (in_fail),
    .vd       (vd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      out_queue   <= '0;
      cmatch      <= 1'b0;
      pmatch      <= 1'b0;
      flush_req   <= 1'b0;
      release_pkt <= 1'b0;
      rules_req   <= 1'b0;
    end else begin
      res_valid   <= live;
      if (acc) out_queue <= in_queue;
      cmatch      <= live & vd.full;
      pmatch      <= live & vd.part;
      flush_req   <= live & vd.full;
      release_pkt <= live & vd.clean;
      rules_req   <= live & (vd.full | vd.part);
    end
  end
endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
  parameter int unsigned QW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          res_valid,
  input logic [QW-1:0] out_queue,
  input logic          cmatch,
  input logic          pmatch,
  input logic          flush_req,
  input logic          release_pkt,
  input logic          rules_req
);
  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n) in_ready); // R2
  AST_RESULT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(in_valid)); // R2
  AST_PULSE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cmatch || pmatch || flush_req || release_pkt || rules_req) |-> res_valid); // R2
  AST_MATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(cmatch && pmatch)); // R6
  AST_RULES_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (cmatch || pmatch) |-> rules_req); // R7
  AST_RULES_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) rules_req |-> (cmatch || pmatch)); // R7
  AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) release_pkt |-> !(cmatch || pmatch)); // R8
  AST_FLUSH_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n) flush_req |-> cmatch); // R9
  AST_FULL_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) cmatch |-> flush_req); // R9
endmodule

bind match_status_classifier msc_checker #(.QW(QW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .res_valid   (res_valid),
  .out_queue   (out_queue),
  .cmatch      (cmatch),
  .pmatch      (pmatch),
  .flush_req   (flush_req),
  .release_pkt (release_pkt),
  .rules_req   (rules_req)
);

// File: tb/match_status_classifier_tb.sv
module match_status_classifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;
  localparam int QW = 3;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [QW-1:0] in_queue = '0;
  logic          in_first = 1'b0, in_root = 1'b0, in_leaf = 1'b0, in_last = 1'b0;
  logic [PW-1:0] in_next = '0, in_fail = '0;
  logic          res_valid;
  logic [QW-1:0] out_queue;
  logic          cmatch, pmatch, flush_req, release_pkt, rules_req;

  int total = 0;
  int bad = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  typedef struct {
    string          tag;
    logic [QW-1:0]  q;
    bit cm, pm, fl, rel, rr;
  } exp_t;
  exp_t sb[$];
  bit   mrv[NQ];
  bit   mig[NQ];
  string quiet_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  match_status_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_queue(in_queue), .in_first(in_first), .in_root(in_root),
    .in_leaf(in_leaf), .in_last(in_last), .in_next(in_next), .in_fail(in_fail),
    .res_valid(res_valid), .out_queue(out_queue), .cmatch(cmatch),
    .pmatch(pmatch), .flush_req(flush_req), .release_pkt(release_pkt),
    .rules_req(rules_req)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(input int q, input bit first, input bit root, input bit leaf,
                      input bit last, input int nx, input int fl, input string tag);
    exp_t e;
    bit rvn;
    bit drop;
    @(negedge clk);
    in_valid = 1'b1; in_queue = QW'(q); in_first = first; in_root = root;
    in_leaf = leaf; in_last = last; in_next = PW'(nx); in_fail = PW'(fl);
    if (first) begin mrv[q] = 1'b0; mig[q] = 1'b0; end
    drop = mig[q];
    e.tag = tag; e.q = QW'(q);
    rvn = mrv[q] | root;
    e.cm = leaf & rvn;
    e.pm = !e.cm && ((leaf && !rvn) || (last && !root && nx != fl));
    e.rel = last && !e.cm && !e.pm;
    e.fl = e.cm;
    e.rr = e.cm | e.pm;
    @(posedge clk);
    #1;
    if (!drop) begin
      mrv[q] = rvn;
      if (e.cm) mig[q] = 1'b1;
      sb.push_back(e);
    end else begin
      quiet_tag = tag;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_leaf = 1'b1; in_last = 1'b1; in_root = 1'b1;
      quiet_tag = "R2";
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, {2'b0, res_valid, cmatch, pmatch, flush_req, release_pkt, rules_req},
                   {2'b0, 1'b1, e.cm, e.pm, e.fl, e.rel, e.rr});
        if (res_valid) chk(e.tag, {5'b0, out_queue}, {5'b0, e.q});
      end else begin
        chk(quiet_tag, {2'b0, res_valid, cmatch, pmatch, flush_req, release_pkt, rules_req}, 8'b0);
      end
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin mrv[i] = 1'b0; mig[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle in reset
    chk("R1", {2'b0, res_valid, cmatch, pmatch, flush_req, release_pkt, rules_req}, 8'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", {7'b0, in_ready}, 8'd1);
    chk("R1", {2'b0, res_valid, cmatch, pmatch, flush_req, release_pkt, rules_req}, 8'b0);
    run = 1'b1;
    send(0, 1, 1, 0, 0, 5, 0, "R3");
    send(0, 0, 0, 0, 0, 6, 1, "R3");
    send(0, 0, 0, 1, 0, 9, 2, "R4");
    send(0, 0, 0, 0, 0, 1, 2, "R9");
    send(0, 0, 0, 1, 1, 4, 2, "R9");
    send(1, 1, 0, 1, 0, 3, 0, "R5");
    send(0, 1, 0, 0, 0, 2, 0, "R11");
    send(0, 0, 0, 1, 0, 8, 0, "R3");
    send(2, 1, 0, 0, 1, 7, 3, "R6");
    send(3, 1, 0, 0, 1, 7, 7, "R8");
    send(4, 1, 1, 0, 1, 7, 3, "R8");
    idle(3);
    send(5, 1, 1, 0, 0, 4, 0, "R10");
    send(6, 1, 0, 0, 0, 4, 1, "R10");
    send(6, 0, 0, 1, 0, 5, 1, "R10");
    send(5, 0, 0, 1, 0, 5, 1, "R4");
    send(6, 0, 0, 0, 1, 2, 5, "R6");
    send(7, 1, 1, 1, 1, 2, 5, "R6");
    send(5, 0, 1, 1, 1, 3, 5, "R9");
    send(7, 0, 0, 0, 1, 3, 5, "R9");
    send(5, 1, 0, 0, 1, 3, 3, "R11");
    idle(4);
    run = 1'b0;
    chk("R2", {7'b0, sb.size() == 0}, 8'd1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule